// File: doc/BRIEF.md
# Charge Safety Timer Pair

This block guards a single-cell battery charger against runaway charging with two cooperating tick counters. An unattended timer covers charging that starts with no host involvement: if it runs out, charging is stopped for good and the charge-inhibit bit must be set. A shorter host watchdog takes over as soon as the host writes any register. The host must keep restarting it with the timer-reset strobe. If the host goes quiet and the watchdog runs out, the register file is told to reload its defaults and unattended charging resumes with the long timer counting again from zero.

Both timers count a slow timebase tick, so their lengths are parameters given in ticks. The disable pin, the thermal-suspend flag and the high-impedance and charge-inhibit register bits gate the counting. Each expiry is reported with single-cycle strobes and a held fault code. The register file, the interface to the host and the analog loops lie outside the block and consume these strobes.

Top module: `chg_safety_timer`

## Requirements
- R1: While reset is low and after it is released, every strobe output is 0 and the fault code is 3'b000; with no start pulse and no register write, no expiry ever occurs, and a reset in the middle of a count discards that count.
- R2: A start pulse while idle, with high-impedance and inhibit both low, starts the unattended timer from zero. On the LONG_TICKS-th counted tick, term_o, set_ce_o and stat_pulse_o are each high for exactly one cycle, and fault_o becomes 3'b110, visible after that clock edge.
- R3: A register write while idle, in unattended mode or after an unattended expiry, with high-impedance and inhibit both low, clears the unattended timer and starts the host watchdog from zero. A write while the watchdog is already running does not restart it.
- R4: On the SHORT_TICKS-th counted tick of the host watchdog, load_dflt_o and stat_pulse_o are high for one cycle and fault_o becomes 3'b110, with term_o and set_ce_o left low. The unattended timer then runs again from zero.
- R5: A timer-reset strobe while the host watchdog runs sets its count back to zero; the strobe's own tick is not counted.
- R6: While the disable pin is high, the host watchdog holds its count and the unattended timer is held at zero.
- R7: While thermal suspend is high, ticks advance neither timer and the counts are kept.
- R8: When high-impedance or inhibit is high, the block returns to idle, the host watchdog is cleared, and start pulses are ignored.
- R9: After an unattended expiry, start pulses are ignored; only a register write (or reset) begins a new cycle.
- R10: fault_o holds its value until fault_clr_i is high for a cycle, which sets it to 3'b000; an expiry in the same cycle as the clear wins and leaves 3'b110.
- R11: Cycles without tick_i advance neither timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one cycle per timer step |
| chg_start_i | input | 1 | Pulse: unattended charging begins |
| reg_wr_i | input | 1 | Pulse: the host wrote a register |
| tmr_rst_i | input | 1 | Pulse: host watchdog restart |
| dis_pin_i | input | 1 | Charge-disable pin level |
| therm_susp_i | input | 1 | Thermal suspend level |
| hiz_i | input | 1 | High-impedance mode bit |
| chg_inh_i | input | 1 | Charge-inhibit bit (1 = charging off) |
| fault_clr_i | input | 1 | Pulse: clear the fault code |
| term_o | output | 1 | Strobe: terminate charging |
| load_dflt_o | output | 1 | Strobe: reload register defaults |
| set_ce_o | output | 1 | Strobe: set the charge-inhibit bit |
| fault_o | output | 3 | Held fault code (3'b110 on timer expiry) |
| stat_pulse_o | output | 1 | Strobe: pulse the status pin |

## Verification
The bench builds the block with LONG_TICKS=6 and SHORT_TICKS=4. At these lengths every expiry, handover and hold is reached within a few dozen cycles of a stimulus table. It also becomes practical to check that an ignored start would have expired inside the observed window. A watchdog expiry followed by a full unattended run, and an expiry that lands on a fault clear, are then short directed runs.

// File: rtl/chg_tmr_pkg.sv
// Shared types for the charge safety timer pair.
// Assumes: nothing beyond the synthesizable subset.
package chg_tmr_pkg;

    // Supervision mode of the timer pair
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,  // no timer running
        MODE_UNATT = 2'd1,  // unattended timer running
        MODE_HOST  = 2'd2,  // host watchdog running
        MODE_HALT  = 2'd3   // unattended expiry, waiting for the host
    } chg_mode_e;

    localparam logic [2:0] FLT_NONE  = 3'b000;
    localparam logic [2:0] FLT_TIMER = 3'b110;

endpackage

// File: rtl/chg_tick_counter.sv
// Tick counter with clear priority and an expiry flag.
// done_o is high in the cycle whose advance completes LIMIT counts;
// the count then wraps to zero. Assumes LIMIT >= 2.
module chg_tick_counter #(
    parameter int unsigned LIMIT = 32,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          adv_i,
    output logic [CW-1:0] cnt_o,
    output logic          done_o
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count advances; clear wins; wrap on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry when the last count is advanced past
    always_comb done_o = adv_i && !clr_i && (cnt_q == LAST);

    assign cnt_o = cnt_q;

endmodule

// File: rtl/chg_tmr_sequencer.sv
// Mode sequencer: decides which timer runs, when counts clear or hold,
// and raises one-cycle expiry events.
// Assumes: the counters report done only on an advanced tick.
// Priority inside a cycle: stop bits, then host strobes, then expiry.
module chg_tmr_sequencer
    import chg_tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      chg_start_i,
    input  logic      reg_wr_i,
    input  logic      tmr_rst_i,
    input  logic      dis_pin_i,
    input  logic      therm_susp_i,
    input  logic      hiz_i,
    input  logic      chg_inh_i,
    input  logic      long_done_i,
    input  logic      short_done_i,
    output logic      long_clr_o,
    output logic      long_adv_o,
    output logic      short_clr_o,
    output logic      short_adv_o,
    output logic      long_ev_o,
    output logic      short_ev_o,
    output chg_mode_e mode_o
);
    chg_mode_e mode_q, mode_d;
    logic      stop, run;

    // Gate terms shared by both timers
    always_comb begin
        stop = hiz_i || chg_inh_i;
        run  = tick_i && !therm_susp_i && !dis_pin_i;
    end

    // Counter control per mode
    always_comb begin
        long_clr_o  = 1'b1;
        long_adv_o  = 1'b0;
        short_clr_o = 1'b1;
        short_adv_o = 1'b0;
        if (mode_q == MODE_UNATT) begin
            long_clr_o = dis_pin_i || stop || reg_wr_i;
            long_adv_o = run && !stop && !reg_wr_i;
        end
        if (mode_q == MODE_HOST) begin
            short_clr_o = tmr_rst_i || stop;
            short_adv_o = run && !stop && !tmr_rst_i;
        end
    end

    // Expiry events from the running timer
    always_comb begin
        long_ev_o  = (mode_q == MODE_UNATT) && long_done_i;
        short_ev_o = (mode_q == MODE_HOST) && short_done_i;
    end

    // Next mode
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_IDLE: begin
                if (!stop && reg_wr_i)         mode_d = MODE_HOST;
                else if (!stop && chg_start_i) mode_d = MODE_UNATT;
            end
            MODE_UNATT: begin
                if (stop)           mode_d = MODE_IDLE;
                else if (reg_wr_i)  mode_d = MODE_HOST;
                else if (long_ev_o) mode_d = MODE_HALT;
            end
            MODE_HOST: begin
                if (stop)            mode_d = MODE_IDLE;
                else if (short_ev_o) mode_d = MODE_UNATT;
            end
            MODE_HALT: begin
                if (!stop && reg_wr_i) mode_d = MODE_HOST;
            end
            default: mode_d = MODE_IDLE;
        endcase
    end

    // Mode register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_IDLE;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/chg_fault_reporter.sv
// Turns expiry events into registered strobes and a held fault code.
// Assumes: at most one expiry event per cycle.
module chg_fault_reporter
    import chg_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       long_ev_i,
    input  logic       short_ev_i,
    input  logic       fault_clr_i,
    output logic       term_o,
    output logic       load_dflt_o,
    output logic       set_ce_o,
    output logic       stat_pulse_o,
    output logic [2:0] fault_o
);
    // One-cycle strobes per expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_o       <= 1'b0;
            set_ce_o     <= 1'b0;
            load_dflt_o  <= 1'b0;
            stat_pulse_o <= 1'b0;
        end else begin
            term_o       <= long_ev_i;
            set_ce_o     <= long_ev_i;
            load_dflt_o  <= short_ev_i;
            stat_pulse_o <= long_ev_i || short_ev_i;
        end
    end

    // Held fault code; an expiry outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                      fault_o <= FLT_NONE;
        else if (long_ev_i || short_ev_i) fault_o <= FLT_TIMER;
        else if (fault_clr_i)            fault_o <= FLT_NONE;
    end

endmodule

// File: rtl/chg_safety_timer.sv
// Top: unattended-charge timer and host-alive watchdog with handover.
// Assumes: tick_i is a one-cycle strobe from a slow timebase; all
// inputs are synchronous to clk; LONG_TICKS and SHORT_TICKS >= 2.
module chg_safety_timer
    import chg_tmr_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 900,
    parameter int unsigned SHORT_TICKS = 32,
    localparam int unsigned LCW = $clog2(LONG_TICKS + 1),
    localparam int unsigned SCW = $clog2(SHORT_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       chg_start_i,
    input  logic       reg_wr_i,
    input  logic       tmr_rst_i,
    input  logic       dis_pin_i,
    input  logic       therm_susp_i,
    input  logic       hiz_i,
    input  logic       chg_inh_i,
    input  logic       fault_clr_i,
    output logic       term_o,
    output logic       load_dflt_o,
    output logic       set_ce_o,
    output logic [2:0] fault_o,
    output logic       stat_pulse_o
);
    logic           long_clr, long_adv, long_done, long_ev;
    logic           short_clr, short_adv, short_done, short_ev;
    logic [LCW-1:0] long_cnt;
    logic [SCW-1:0] short_cnt;
    chg_mode_e      mode;

    chg_tmr_sequencer i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .chg_start_i  (chg_start_i),
        .reg_wr_i     (reg_wr_i),
        .tmr_rst_i    (tmr_rst_i),
        .dis_pin_i    (dis_pin_i),
        .therm_susp_i (therm_susp_i),
        .hiz_i        (hiz_i),
        .chg_inh_i    (chg_inh_i),
        .long_done_i  (long_done),
        .short_done_i (short_done),
        .long_clr_o   (long_clr),
        .long_adv_o   (long_adv),
        .short_clr_o  (short_clr),
        .short_adv_o  (short_adv),
        .long_ev_o    (long_ev),
        .short_ev_o   (short_ev),
        .mode_o       (mode)
    );

    chg_tick_counter #(.LIMIT(LONG_TICKS)) i_long_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (long_clr),
        .adv_i  (long_adv),
        .cnt_o  (long_cnt),
        .done_o (long_done)
    );

    chg_tick_counter #(.LIMIT(SHORT_TICKS)) i_short_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (short_clr),
        .adv_i  (short_adv),
        .cnt_o  (short_cnt),
        .done_o (short_done)
    );

    chg_fault_reporter i_rpt (
        .clk          (clk),
        .rst_n        (rst_n),
        .long_ev_i    (long_ev),
        .short_ev_i   (short_ev),
        .fault_clr_i  (fault_clr_i),
        .term_o       (term_o),
        .load_dflt_o  (load_dflt_o),
        .set_ce_o     (set_ce_o),
        .stat_pulse_o (stat_pulse_o),
        .fault_o      (fault_o)
    );

endmodule

// File: rtl/chg_tmr_checker.sv
// Property checker for chg_safety_timer, attached by bind below.
// Assumes: the same parameters as the bound instance.
module chg_tmr_checker
    import chg_tmr_pkg::*;
#(
    parameter int unsigned LCW = 10,
    parameter int unsigned SCW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_i,
    input logic           reg_wr_i,
    input logic           tmr_rst_i,
    input logic           dis_pin_i,
    input logic           therm_susp_i,
    input logic           hiz_i,
    input logic           chg_inh_i,
    input logic           fault_clr_i,
    input chg_mode_e      mode,
    input logic [LCW-1:0] long_cnt,
    input logic [SCW-1:0] short_cnt,
    input logic           term_o,
    input logic           load_dflt_o,
    input logic           set_ce_o,
    input logic [2:0]     fault_o,
    input logic           stat_pulse_o
);
    logic stop;
    always_comb stop = hiz_i || chg_inh_i;

    a_r2_term_from_unatt: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |-> $past(mode) == MODE_UNATT);

    a_r4_reload_no_term: assert property (@(posedge clk) disable iff (!rst_n)
        load_dflt_o |-> !term_o && !set_ce_o);

    a_r5_trst_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOST && tmr_rst_i) |=> short_cnt == '0);

    a_r6_dis_long_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UNATT && dis_pin_i) |=> long_cnt == '0);

    a_r7_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOST && therm_susp_i && !tmr_rst_i && !stop)
        |=> $stable(short_cnt));

    a_r9_halt_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALT && !reg_wr_i) |=> mode == MODE_HALT);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pulse_o |=> !stat_pulse_o);

    a_r10_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(fault_clr_i) && !stat_pulse_o) |-> $stable(fault_o));

    a_r11_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UNATT && !tick_i && !dis_pin_i && !reg_wr_i && !stop)
        |=> $stable(long_cnt));

endmodule

bind chg_safety_timer chg_tmr_checker #(.LCW(LCW), .SCW(SCW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .reg_wr_i     (reg_wr_i),
    .tmr_rst_i    (tmr_rst_i),
    .dis_pin_i    (dis_pin_i),
    .therm_susp_i (therm_susp_i),
    .hiz_i        (hiz_i),
    .chg_inh_i    (chg_inh_i),
    .fault_clr_i  (fault_clr_i),
    .mode         (mode),
    .long_cnt     (long_cnt),
    .short_cnt    (short_cnt),
    .term_o       (term_o),
    .load_dflt_o  (load_dflt_o),
    .set_ce_o     (set_ce_o),
    .fault_o      (fault_o),
    .stat_pulse_o (stat_pulse_o)
);

// File: tb/test_chg_safety_timer.sv
module test_chg_safety_timer;
    localparam int unsigned LT = 6;
    localparam int unsigned ST = 4;
    localparam int NV = 44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, start = 0, wr = 0, trst = 0, dis = 0, susp = 0;
    logic hiz = 0, inh = 0, fclr = 0;
    logic term, ld, ce, stat;
    logic [2:0] fault;
    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    chg_safety_timer #(.LONG_TICKS(LT), .SHORT_TICKS(ST)) i_chg_safety_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .chg_start_i(start),
        .reg_wr_i(wr), .tmr_rst_i(trst), .dis_pin_i(dis),
        .therm_susp_i(susp), .hiz_i(hiz), .chg_inh_i(inh),
        .fault_clr_i(fclr), .term_o(term), .load_dflt_o(ld),
        .set_ce_o(ce), .fault_o(fault), .stat_pulse_o(stat)
    );

    // Inputs {start,wr,trst,dis,susp,hiz,inh,tick,fclr}
    // then expected {term,ld,ce,stat,fault[2:0]} after that cycle's edge
    localparam logic [15:0] VEC [NV] = '{
        16'b100000010_0000000, // 0  R2 start
        16'b000000010_0000000, // 1
        16'b000000010_0000000, // 2
        16'b000100010_0000000, // 3  R6 disable clears long
        16'b000000010_0000000, // 4
        16'b000000010_0000000, // 5
        16'b000010010_0000000, // 6  R7 suspend
        16'b000000010_0000000, // 7
        16'b000000010_0000000, // 8
        16'b000000010_0000000, // 9
        16'b000000010_1011110, // 10 R2 expiry
        16'b000000010_0000110, // 11
        16'b100000010_0000110, // 12 R9 start ignored
        16'b000000010_0000110, // 13
        16'b000000010_0000110, // 14
        16'b000000010_0000110, // 15
        16'b000000010_0000110, // 16
        16'b000000010_0000110, // 17
        16'b000000010_0000110, // 18
        16'b000000011_0000000, // 19 R10 clear
        16'b010000010_0000000, // 20 R3 write -> host
        16'b000000010_0000000, // 21
        16'b001000010_0000000, // 22 R5 timer reset
        16'b000000010_0000000, // 23
        16'b000000010_0000000, // 24
        16'b000100010_0000000, // 25 R6 hold
        16'b000000010_0000000, // 26
        16'b010000010_0101110, // 27 R4 expiry, write no restart
        16'b000000010_0000110, // 28
        16'b010000010_0000110, // 29 R3 handover
        16'b000000010_0000110, // 30
        16'b000001010_0000110, // 31 R8 hiz
        16'b000000010_0000110, // 32
        16'b000000010_0000110, // 33
        16'b000000010_0000110, // 34
        16'b000000010_0000110, // 35
        16'b100000110_0000110, // 36 R8 start blocked by inhibit
        16'b000000010_0000110, // 37
        16'b000000010_0000110, // 38
        16'b000000010_0000110, // 39
        16'b000000010_0000110, // 40
        16'b000000010_0000110, // 41
        16'b000000010_0000110, // 42
        16'b000000011_0000000  // 43 R10 clear
    };

    function automatic string row_tag(int i);
        if (i == 3 || i == 25 || i == 26) return "R6";
        if (i == 6)  return "R7";
        if (i <= 11) return "R2";
        if (i <= 18) return "R9";
        if (i == 19 || i == 43) return "R10";
        if (i >= 22 && i <= 24) return "R5";
        if (i == 27) return "R4";
        if (i <= 30) return "R3";
        return "R8";
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] outs();
        return {term, ld, ce, stat, fault};
    endfunction

    task automatic idle_inputs();
        {start, wr, trst, dis, susp, hiz, inh, tick, fclr} = '0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    // n ticks; outputs must stay quiet until the last, which shows exp
    task automatic tick_run(int n, string tag, logic [6:0] quiet, logic [6:0] exp);
        idle_inputs();
        tick = 1'b1;
        for (int k = 1; k <= n; k++) begin
            step();
            check(tag, outs(), (k == n) ? exp : quiet);
        end
    endtask

    initial begin
        do_reset();
        check("R1", outs(), 7'b0000000);
        // R1: ticks without start never expire
        tick_run(10, "R1", 7'b0000000, 7'b0000000);

        for (int i = 0; i < NV; i++) begin
            {start, wr, trst, dis, susp, hiz, inh, tick, fclr} = VEC[i][15:7];
            step();
            check(row_tag(i), outs(), VEC[i][6:0]);
        end

        // R11: no tick, no advance
        do_reset();
        start = 1'b1; step(); start = 1'b0;
        for (int k = 0; k < 20; k++) step();
        check("R11", outs(), 7'b0000000);
        tick_run(LT, "R11", 7'b0000000, 7'b1011110);

        // R4 then R2: watchdog expiry restarts unattended timer from zero
        do_reset();
        wr = 1'b1; step(); wr = 1'b0;
        tick_run(ST, "R4", 7'b0000000, 7'b0101110);
        tick_run(LT, "R4", 7'b0000110, 7'b1011110);

        // R10: expiry in the same cycle as a clear keeps 110
        do_reset();
        wr = 1'b1; step(); wr = 1'b0;
        tick_run(ST - 1, "R10", 7'b0000000, 7'b0000000);
        tick = 1'b1; fclr = 1'b1; step();
        check("R10", outs(), 7'b0101110);
        idle_inputs(); step();
        check("R10", outs(), 7'b0000110);

        // R1: reset mid-count discards progress
        do_reset();
        start = 1'b1; step(); start = 1'b0;
        tick_run(LT - 1, "R1", 7'b0000000, 7'b0000000);
        do_reset();
        check("R1", outs(), 7'b0000000);
        tick_run(LT + 2, "R1", 7'b0000000, 7'b0000000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule